// File: doc/BRIEF.md
# SD Command and Response Engine

This block sends one SD/MMC command frame on the CMD line and collects the card's reply. The caller presents a 6-bit command index, a 32-bit argument, a response length and three option flags, then pulses `start`. The engine shifts out the 48-bit frame, with a CRC7 it computes itself. It then releases the line and waits a bounded time for the card's start bit. It shifts in the programmed number of response bits and checks their CRC7. If asked, it also holds off completion while the card keeps DAT0 low.

Software-visible results are a CRC-good bit, a timeout bit, a busy flag, a one-cycle completion pulse and a state code. The captured response is read one 32-bit word at a time. The read position returns to word 0 after each completion and moves on by one for every `rd_next` pulse. A long (136-bit) response comes out as four words, least significant first. The engine moves one bit per clock, so `clk` is the card bit clock.

Top module: `sdcmd_engine`

## Requirements
- R1: On an accepted `start`, `cmd_oe` rises on the next clock and stays high for exactly 48 cycles. On `cmd_o`, MSB first, it carries: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a CRC7 over those first 40 bits (polynomial x^7+x^3+1, register cleared to zero), and a 1 end bit.
- R2: A `start` pulse that arrives while `cmd_busy` is high is ignored, and the frame in flight is unchanged.
- R3: `resp_bits` holds the response length minus one, for example 47 for a 48-bit reply and 135 for a 136-bit reply. A value of 0 means no response. In that case, with busy wait off, `done` pulses on the same clock edge that drops `cmd_oe`.
- R4: Number the received bits backwards from the end bit, which is bit 0. Bit j of response word k is then received bit 32k+8+j. Word 0 is the 32-bit payload of a short reply.
- R5: `crc_ok` is set at the end bit when the CRC7 remainder over the checked bits and the received CRC is zero. With `crc_from8` clear, checking starts at the start bit. With it set, checking starts at the ninth received bit.
- R6: With `crc_skip` set, `crc_ok` reads 1 at completion whatever CRC the card sent.
- R7: The engine samples for a 0 start bit on `cmd_i` for at most 64 clocks after release. A start bit on the 64th sample is accepted. If none arrives, `timeout` is set and `done` pulses on that 64th clock.
- R8: With `busy_chk` set, after the response (or after release if there is no response) the engine stays in state code 4 while `dat0_i` is 0. It completes on the first clock that samples `dat0_i` high.
- R9: The read index is 0 after every completion. Each `rd_next` pulse advances it by one and wraps from 3 to 0. `resp_word` shows the selected word one clock after the index changes.
- R10: `cmd_busy` is high from acceptance until completion. `done` is a single-cycle pulse that coincides with `cmd_busy` falling. `state_code` reads 0 idle, 1 sending, 2 awaiting reply, 3 receiving, 4 busy wait.
- R11: `rst` or `soft_rst` returns the engine to idle on the next clock. They clear `cmd_busy`, `cmd_oe`, `timeout`, `crc_ok` and the captured response, and leave `cmd_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous return to idle with status clear |
| start | input | 1 | Launch a command when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_bits | input | 8 | Response length minus one, 0 for none |
| crc_skip | input | 1 | Report response CRC as good |
| crc_from8 | input | 1 | Start response CRC at the ninth bit |
| busy_chk | input | 1 | Wait for DAT0 high before completing |
| cmd_i | input | 1 | CMD line as seen from the card |
| dat0_i | input | 1 | DAT0 line level |
| rd_next | input | 1 | Advance the response read index |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| resp_word | output | 32 | Selected response word |
| crc_ok | output | 1 | Response CRC good |
| timeout | output | 1 | No response start bit in time |
| cmd_busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| state_code | output | 4 | Engine state |

## Verification
Some properties are checked on every clock: the 48-cycle drive window with its low start bit and high end bit, the single-cycle completion pulse tied to the busy flag falling, the rule that completion never happens while DAT0 is low in busy wait, the length of the reply window before a timeout, and the reset clearing. Other properties need whole scenarios to show. These are the bit-exact frame contents and their CRC7 (against known command encodings), the response word mapping for short and long replies, CRC pass and fail with both coverage starts and the skip flag, the start bit accepted on the last allowed sample, a start that is ignored mid-frame, and read-index wrapping.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_SEND = 4'd1,
    ST_WAIT = 4'd2,
    ST_RECV = 4'd3,
    ST_BUSY = 4'd4
  } eng_state_t;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] cur,
                                                 input logic bit_in);
    logic fb;
    fb = bit_in ^ cur[CRC_W-1];
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_rsp_store.sv
module sdcmd_rsp_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEAD_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              idx_clr,
  input  logic              shift_en,
  input  logic              din,
  input  logic              rd_next,
  output logic [WORD_W-1:0] word_o
);
  localparam int SR_W  = NUM_WORDS * WORD_W + LEAD_BITS;
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  logic [SR_W-1:0]   sr;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] words [NUM_WORDS];

  // newest bit enters at position 0; words sit above the trailing bits
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign words[k] = sr[k*WORD_W + LEAD_BITS +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst || idx_clr) idx <= '0;
    else if (rd_next)   idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= words[idx];
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int RB_W      = 8,
  parameter int TO_CYC    = 64,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEAD_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [RB_W-1:0]   resp_bits,
  input  logic              crc_skip,
  input  logic              crc_from8,
  input  logic              busy_chk,
  input  logic              cmd_i,
  input  logic              dat0_i,
  input  logic              rd_next,
  output logic              cmd_o,
  output logic              cmd_oe,
  output logic [WORD_W-1:0] resp_word,
  output logic              crc_ok,
  output logic              timeout,
  output logic              cmd_busy,
  output logic              done,
  output logic [3:0]        state_code
);
  localparam int CMD_BITS   = 2 + IDX_W + ARG_W;
  localparam int FRAME_BITS = CMD_BITS + CRC_W + 1;
  localparam int TXC_W      = $clog2(FRAME_BITS + 1);
  localparam int TOC_W      = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;
  localparam logic [TXC_W-1:0] TXC_CMD_END = TXC_W'(CMD_BITS);
  localparam logic [TXC_W-1:0] TXC_END_BIT = TXC_W'(FRAME_BITS - 1);
  localparam logic [TXC_W-1:0] TXC_CRC_TOP = TXC_W'(FRAME_BITS - 2);
  localparam logic [TOC_W-1:0] TO_LAST     = TOC_W'(TO_CYC - 1);
  localparam logic [RB_W-1:0]  COV_LATE    = RB_W'(LEAD_BITS);

  eng_state_t          state;
  logic [CMD_BITS-1:0] tx_sr;
  logic [TXC_W-1:0]    tx_cnt;
  logic [RB_W-1:0]     rx_cnt;
  logic [TOC_W-1:0]    to_cnt;
  logic [RB_W-1:0]     r_bits;
  logic                r_from8, r_skip, r_busy;
  logic                cmd_o_q, cmd_oe_q, busy_q, crc_ok_q, tmo_q, done_q;
  logic [CRC_W-1:0]    tx_crc, rx_crc;
  logic [2:0]          crc_pos;
  logic [RB_W-1:0]     cov_start;
  logic                rst_all, accept, tx_crc_en, rx_crc_en, rx_shift;

  assign rst_all   = rst | soft_rst;
  assign accept    = (state == ST_IDLE) && start;
  assign crc_pos   = 3'(TXC_CRC_TOP - tx_cnt);
  assign cov_start = r_from8 ? COV_LATE : '0;
  assign tx_crc_en = (state == ST_SEND) && (tx_cnt < TXC_CMD_END);
  assign rx_shift  = ((state == ST_WAIT) && !cmd_i) || (state == ST_RECV);
  assign rx_crc_en = ((state == ST_WAIT) && !cmd_i && !r_from8) ||
                     ((state == ST_RECV) && (rx_cnt >= cov_start) && (rx_cnt < r_bits));

  sdcmd_crc7 u_tx_crc (
    .clk(clk), .rst(rst_all), .clr(accept), .en(tx_crc_en),
    .din(tx_sr[CMD_BITS-1]), .crc(tx_crc)
  );

  sdcmd_crc7 u_rx_crc (
    .clk(clk), .rst(rst_all), .clr(accept), .en(rx_crc_en),
    .din(cmd_i), .crc(rx_crc)
  );

  sdcmd_rsp_store #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .LEAD_BITS(LEAD_BITS)
  ) u_store (
    .clk(clk), .rst(rst_all), .clr(accept), .idx_clr(accept | done_q),
    .shift_en(rx_shift), .din(cmd_i), .rd_next(rd_next), .word_o(resp_word)
  );

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst_all) begin
      state    <= ST_IDLE;
      tx_sr    <= '0;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      to_cnt   <= '0;
      r_bits   <= '0;
      r_from8  <= 1'b0;
      r_skip   <= 1'b0;
      r_busy   <= 1'b0;
      cmd_o_q  <= 1'b1;
      cmd_oe_q <= 1'b0;
      busy_q   <= 1'b0;
      crc_ok_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            tx_sr    <= {2'b01, cmd_idx, cmd_arg};
            tx_cnt   <= '0;
            r_bits   <= resp_bits;
            r_from8  <= crc_from8;
            r_skip   <= crc_skip;
            r_busy   <= busy_chk;
            busy_q   <= 1'b1;
            crc_ok_q <= 1'b0;
            tmo_q    <= 1'b0;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          tx_cnt   <= tx_cnt + 1'b1;
          cmd_oe_q <= 1'b1;
          if (tx_cnt < TXC_CMD_END) begin
            cmd_o_q <= tx_sr[CMD_BITS-1];
            tx_sr   <= tx_sr << 1;
          end else if (tx_cnt < TXC_END_BIT) begin
            cmd_o_q <= tx_crc[crc_pos];
          end else if (tx_cnt == TXC_END_BIT) begin
            cmd_o_q <= 1'b1;
          end else begin
            cmd_oe_q <= 1'b0;
            cmd_o_q  <= 1'b1;
            to_cnt   <= '0;
            rx_cnt   <= '0;
            if (r_bits != '0) state <= ST_WAIT;
            else if (r_busy)  state <= ST_BUSY;
            else begin
              state  <= ST_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            rx_cnt <= RB_W'(1);
            state  <= ST_RECV;
          end else if (to_cnt == TO_LAST) begin
            tmo_q  <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_RECV: begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == r_bits) begin
            crc_ok_q <= r_skip || (rx_crc == '0);
            if (r_busy) state <= ST_BUSY;
            else begin
              state  <= ST_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (dat0_i) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o      = cmd_o_q;
  assign cmd_oe     = cmd_oe_q;
  assign crc_ok     = crc_ok_q;
  assign timeout    = tmo_q;
  assign cmd_busy   = busy_q;
  assign done       = done_q;
  assign state_code = state;

endmodule

// File: rtl/sdcmd_checks.sv
module sdcmd_checks #(
  parameter int FRAME_BITS = 48,
  parameter int TO_CYC     = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       cmd_o,
  input logic       cmd_oe,
  input logic       cmd_busy,
  input logic       done,
  input logic       timeout,
  input logic       crc_ok,
  input logic       dat0_i,
  input logic [3:0] state_code
);
  logic       rst_any;
  logic [7:0] oe_run;
  logic [7:0] wait_run;

  assign rst_any = rst | soft_rst;

  always_ff @(posedge clk) begin
    if (rst_any || !cmd_oe) oe_run <= '0;
    else                    oe_run <= oe_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_any || state_code != 4'd2) wait_run <= '0;
    else                               wait_run <= wait_run + 1'b1;
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst_any)
    ($fell(cmd_oe) && !$past(rst_any)) |-> (oe_run == 8'(FRAME_BITS))); // R1
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst_any)
    $rose(cmd_oe) |-> !cmd_o); // R1
  AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (rst_any)
    ($fell(cmd_oe) && !$past(rst_any)) |-> $past(cmd_o)); // R1
  AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (rst_any)
    $rose(timeout) |-> (wait_run == 8'(TO_CYC))); // R7
  AST_TMO_DONE: assert property (@(posedge clk) disable iff (rst_any)
    $rose(timeout) |=> !done); // R7
  AST_DAT0_HOLD: assert property (@(posedge clk) disable iff (rst_any)
    (state_code == 4'd4 && !dat0_i) |=> !done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst_any)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst_any)
    done |-> (!cmd_busy && state_code == 4'd0)); // R10
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst_any)
    ($fell(cmd_busy) && !$past(rst_any)) |-> done); // R10
  AST_OE_IN_CMD: assert property (@(posedge clk) disable iff (rst_any)
    cmd_oe |-> cmd_busy); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst_any |=> (!cmd_busy && !cmd_oe && !timeout && !crc_ok && cmd_o)); // R11

endmodule

bind sdcmd_engine sdcmd_checks #(
  .FRAME_BITS(2 + IDX_W + ARG_W + 8),
  .TO_CYC(TO_CYC)
) u_checks (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
  .cmd_busy(cmd_busy), .done(done), .timeout(timeout), .crc_ok(crc_ok),
  .dat0_i(dat0_i), .state_code(state_code)
);

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, soft_rst = 1'b0, start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  resp_bits = '0;
  logic        crc_skip = 1'b0, crc_from8 = 1'b0, busy_chk = 1'b0;
  logic        cmd_i = 1'b1, dat0_i = 1'b1, rd_next = 1'b0;
  logic        cmd_o, cmd_oe, crc_ok, timeout, cmd_busy, done;
  logic [31:0] resp_word;
  logic [3:0]  state_code;

  int checks = 0;
  int fails  = 0;

  sdcmd_engine u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .resp_bits(resp_bits), .crc_skip(crc_skip),
    .crc_from8(crc_from8), .busy_chk(busy_chk), .cmd_i(cmd_i), .dat0_i(dat0_i),
    .rd_next(rd_next), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .resp_word(resp_word),
    .crc_ok(crc_ok), .timeout(timeout), .cmd_busy(cmd_busy), .done(done),
    .state_code(state_code)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        long_r;
    logic [31:0] seed;
    logic [6:0]  flip;
    logic        skip;
    logic [7:0]  gap;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{6'd8,  32'h000001AA, 1'b0, 32'h000001AA, 7'h00, 1'b0, 8'd2},
    '{6'd17, 32'h00001000, 1'b0, 32'h00000900, 7'h00, 1'b0, 8'd0},
    '{6'd2,  32'h00000000, 1'b1, 32'hCAFEF00D, 7'h00, 1'b0, 8'd5},
    '{6'd9,  32'hABCD0000, 1'b1, 32'h12345678, 7'h04, 1'b0, 8'd1},
    '{6'd13, 32'h00010000, 1'b0, 32'h00000F00, 7'h01, 1'b0, 8'd63},
    '{6'd55, 32'hFFFFFFFF, 1'b0, 32'h80000000, 7'h10, 1'b1, 8'd3},
    '{6'd3,  32'h00000000, 1'b1, 32'h0BADBEEF, 7'h40, 1'b1, 8'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
    logic [6:0] c;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] f;
    f = {2'b01, idx, arg};
    return {f, ref_crc({88'b0, f}, 40), 1'b1};
  endfunction

  logic [47:0] got_frame;
  int          got_len;

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] rb,
                       input logic skip, input logic f8, input logic bz, input bit poke);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; resp_bits = rb;
    crc_skip = skip; crc_from8 = f8; busy_chk = bz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_len = 0; got_frame = '0;
    @(negedge clk);
    while (cmd_oe && got_len < 60) begin
      got_frame = {got_frame[46:0], cmd_o};
      got_len++;
      if (poke && got_len == 10) begin
        start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic respond(input logic [135:0] fr, input int n, input int gap);
    repeat (gap) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_i = fr[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse_next();
    rd_next = 1'b1;
    @(negedge clk);
    rd_next = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    logic [135:0] fr;
    logic [119:0] pay;
    logic [6:0]   c;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset cmd_oe", 64'(cmd_oe), 64'(0));
    chk("R11 reset cmd_busy", 64'(cmd_busy), 64'(0));
    chk("R11 reset cmd_o high", 64'(cmd_o), 64'(1));
    chk("R10 reset state idle", 64'(state_code), 64'(0));
    chk("R11 reset resp_word", 64'(resp_word), 64'(0));

    // R1 / R3: known encodings, no response expected
    issue(6'd0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 frame length", 64'(got_len), 64'(48));
    chk("R1 idle command frame", 64'(got_frame), 64'(48'h400000000095));
    chk("R3 done at release", 64'(done), 64'(1));
    chk("R10 busy low at done", 64'(cmd_busy), 64'(0));
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'(0));
    issue(6'd8, 32'h000001AA, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 interface condition frame", 64'(got_frame), 64'(48'h48000001AA87));

    // table of commands with replies
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      int n;
      t = VECS[v];
      n = t.long_r ? 136 : 48;
      issue(t.idx, t.arg, t.long_r ? 8'd135 : 8'd47, t.skip, t.long_r, 1'b0, 1'b0);
      chk("R1 table frame", 64'(got_frame), 64'(cmd_frame(t.idx, t.arg)));
      if (t.long_r) begin
        pay = {t.seed, ~t.seed, t.seed ^ 32'hA5A5A5A5, t.seed[23:0]};
        c   = ref_crc({8'b0, pay}, 120);
        fr  = {2'b00, 6'h3F, pay, c ^ t.flip, 1'b1};
      end else begin
        c  = ref_crc({88'b0, 2'b00, t.idx, t.seed}, 40);
        fr = {88'b0, 2'b00, t.idx, t.seed, c ^ t.flip, 1'b1};
      end
      respond(fr, n, int'(t.gap));
      wait_done(k);
      chk("R10 table done", 64'(done), 64'(1));
      chk("R5/R6 crc_ok", 64'(crc_ok), 64'((t.flip == 7'h00) || t.skip));
      chk("R7 no timeout", 64'(timeout), 64'(0));
      @(negedge clk);
      chk("R10 table done pulse", 64'(done), 64'(0));
      @(negedge clk);
      chk("R4 word0", 64'(resp_word), 64'(fr[8 +: 32]));
      if (t.long_r) begin
        for (int w = 1; w < 4; w++) begin
          pulse_next();
          chk("R4 long word", 64'(resp_word), 64'(fr[32*w + 8 +: 32]));
        end
        pulse_next();
        chk("R9 index wrap", 64'(resp_word), 64'(fr[8 +: 32]));
      end
    end

    // R7 timeout after 64 samples
    issue(6'd5, 32'h0, 8'd47, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_done(k);
    chk("R7 timeout latency", 64'(k), 64'(64));
    chk("R7 timeout flag", 64'(timeout), 64'(1));
    chk("R5 crc_ok low on timeout", 64'(crc_ok), 64'(0));
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R11 soft reset clears timeout", 64'(timeout), 64'(0));
    @(negedge clk);
    chk("R11 soft reset clears response", 64'(resp_word), 64'(0));

    // R8 busy wait on DAT0
    dat0_i = 1'b0;
    issue(6'd7, 32'h00020000, 8'd47, 1'b0, 1'b0, 1'b1, 1'b0);
    c  = ref_crc({88'b0, 2'b00, 6'd7, 32'h00000700}, 40);
    fr = {88'b0, 2'b00, 6'd7, 32'h00000700, c, 1'b1};
    respond(fr, 48, 0);
    k = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) k++;
      @(negedge clk);
    end
    chk("R8 no done while DAT0 low", 64'(k), 64'(0));
    chk("R8 busy wait state", 64'(state_code), 64'(4));
    chk("R10 busy held", 64'(cmd_busy), 64'(1));
    dat0_i = 1'b1;
    @(negedge clk);
    chk("R8 done after DAT0 release", 64'(done), 64'(1));
    chk("R8 crc ok", 64'(crc_ok), 64'(1));

    // R2 start ignored mid-frame
    issue(6'd24, 32'h13572468, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 frame unchanged", 64'(got_frame), 64'(cmd_frame(6'd24, 32'h13572468)));
    chk("R2 single frame", 64'(got_len), 64'(48));
    repeat (3) @(negedge clk);
    chk("R2 no second command", 64'(cmd_busy), 64'(0));

    // R11 soft reset mid-frame
    @(negedge clk);
    cmd_idx = 6'd12; resp_bits = 8'd47; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R11 mid-frame oe", 64'(cmd_oe), 64'(0));
    chk("R11 mid-frame busy", 64'(cmd_busy), 64'(0));
    chk("R11 mid-frame cmd_o", 64'(cmd_o), 64'(1));
    chk("R10 idle after soft reset", 64'(state_code), 64'(0));

    // recovery after soft reset
    issue(6'd0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 frame after soft reset", 64'(got_frame), 64'(48'h400000000095));

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule